// File: doc/BRIEF.md
# Conditional masked copy engine

This block copies a run of 32-bit words from a source buffer to a destination buffer and filters them one by one on the way. A processor sets it up through a small register port. It writes the source base, the destination base, the number of elements, a mask word, a compare word and a polarity bit, and then sets the start bit. The engine reads the source words in order through a read-only bus master. Each returned word is ANDed with the mask and compared with the compare word, and the word goes out on a separate write-only bus master only when the test passes. Destination locations of rejected words are not touched, which makes the block suitable for transparency-keyed blits.

The settings are snapshotted when a run starts. They also stay in the registers afterwards, so writing the start bit again repeats the same transfer without any reload. Up to `DEPTH` reads can be outstanding, and both masters follow a waitrequest handshake. With no stalls, the engine therefore retires one element per clock.

The controller has five states. `S_IDLE` waits for an accepted start and goes to `S_LOAD`. `S_LOAD` goes to `S_FINISH` when the count is zero and to `S_STREAM` otherwise. `S_STREAM` issues reads and goes to `S_DRAIN` once every read has been issued. `S_DRAIN` waits until every element has been written or skipped and then goes to `S_FINISH`. `S_FINISH` sets the done flag and returns to `S_IDLE`.

Top module: `mask_copy_engine`

## Requirements
- R1: After reset the status word reads 0, and neither `rd_read` nor `wr_write` is asserted.
- R2: The register word indices are 0 control (bit0 start, write only; bit1 invert, read/write), 1 status, 2 source base, 3 destination base, 4 element count, 5 mask, 6 compare value. Every setup register reads back its last written value after a run. A start with no new setup repeats the identical transfer.
- R3: A run of N elements issues exactly N reads, at source base + 4*i for i = 0..N-1, in increasing order, and each one once.
- R4: While a strobe is asserted with its waitrequest high, the strobe, the address and (for writes) the data stay unchanged into the next cycle.
- R5: Element i is written to destination base + 4*i with the read data unchanged exactly when ((data & mask) != compare) XOR invert is 1. Writes come out in element order.
- R6: The destination word of a rejected element keeps its previous contents.
- R7: With both waitrequests held low, a run of N elements ends (busy drops) within N + read latency + 8 cycles after the start is accepted.
- R8: Status bit0 (busy) is 1 from the accepted start until the run ends. Status bit1 (done) is cleared by an accepted start, set when the run ends, and otherwise held. The two bits are never 1 together.
- R9: A start written while busy is ignored. Setup writes made during a run change the registers but not the run in progress.
- R10: A run with element count 0 sets done and produces no bus strobe on either master.
- R11: Busy drops only after the last passing write has been accepted. No strobe is asserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_address | input | 3 | Register word index |
| csr_write | input | 1 | Register write strobe |
| csr_writedata | input | W | Register write data |
| csr_readdata | output | W | Register read data (combinational) |
| rd_address | output | W | Source read byte address |
| rd_read | output | 1 | Source read strobe |
| rd_waitrequest | input | 1 | Source stall; read not taken this cycle |
| rd_readdata | input | W | Source read data |
| rd_readdatavalid | input | 1 | Source read data valid, in request order |
| wr_address | output | W | Destination write byte address |
| wr_write | output | 1 | Destination write strobe |
| wr_writedata | output | W | Destination write data |
| wr_waitrequest | input | 1 | Destination stall; write not taken this cycle |

## Verification
The assertions assume that the source memory returns exactly one `rd_readdatavalid` pulse for each accepted read, in request order, and never one without a pending request. The FIFO overflow and credit checks depend on this. The bench memory model keeps a pending-response queue that is filled only by accepted reads and drained in order, and it returns data a fixed number of cycles after acceptance. Waitrequest patterns come from a pseudo-random sequence and are applied only through the inputs the protocol allows to stall.

// File: rtl/mce_pkg.sv
package mce_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_STREAM,
        S_DRAIN,
        S_FINISH
    } eng_state_t;

    localparam int CSR_AW = 3;

    localparam logic [CSR_AW-1:0] A_CTRL = 3'd0;
    localparam logic [CSR_AW-1:0] A_STAT = 3'd1;
    localparam logic [CSR_AW-1:0] A_SRC  = 3'd2;
    localparam logic [CSR_AW-1:0] A_DST  = 3'd3;
    localparam logic [CSR_AW-1:0] A_CNT  = 3'd4;
    localparam logic [CSR_AW-1:0] A_MASK = 3'd5;
    localparam logic [CSR_AW-1:0] A_CMP  = 3'd6;

    localparam int B_START = 0;
    localparam int B_INV   = 1;
    localparam int B_BUSY  = 0;
    localparam int B_DONE  = 1;

endpackage

// File: rtl/mce_regs.sv
module mce_regs
    import mce_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_address,
    input  logic              csr_write,
    input  logic [W-1:0]      csr_writedata,
    output logic [W-1:0]      csr_readdata,
    input  logic              busy,
    input  logic              finish,
    output logic              start_go,
    output logic [W-1:0]      src_base,
    output logic [W-1:0]      dst_base,
    output logic [W-1:0]      elem_count,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      cmpv,
    output logic              invert
);

    logic done_q;

    // a start is taken only when the engine is idle
    assign start_go = csr_write && (csr_address == A_CTRL)
                      && csr_writedata[B_START] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base   <= '0;
            dst_base   <= '0;
            elem_count <= '0;
            mask       <= '0;
            cmpv       <= '0;
            invert     <= 1'b0;
        end else if (csr_write) begin
            unique case (csr_address)
                A_CTRL:  invert     <= csr_writedata[B_INV];
                A_SRC:   src_base   <= csr_writedata;
                A_DST:   dst_base   <= csr_writedata;
                A_CNT:   elem_count <= csr_writedata;
                A_MASK:  mask       <= csr_writedata;
                A_CMP:   cmpv       <= csr_writedata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (start_go) done_q <= 1'b0;
        else if (finish)   done_q <= 1'b1;
    end

    always_comb begin
        csr_readdata = '0;
        unique case (csr_address)
            A_CTRL: csr_readdata[B_INV] = invert;
            A_STAT: begin
                csr_readdata[B_BUSY] = busy;
                csr_readdata[B_DONE] = done_q;
            end
            A_SRC:   csr_readdata = src_base;
            A_DST:   csr_readdata = dst_base;
            A_CNT:   csr_readdata = elem_count;
            A_MASK:  csr_readdata = mask;
            A_CMP:   csr_readdata = cmpv;
            default: csr_readdata = '0;
        endcase
    end

    // R8: done and busy are exclusive
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && busy));

    // R8: done rises only on a finishing cycle
    p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(finish));

endmodule

// File: rtl/mce_fetch.sv
module mce_fetch #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src_base,
    input  logic [W-1:0] elem_count,
    input  logic         enable,
    output logic [W-1:0] rd_address,
    output logic         rd_read,
    input  logic         rd_waitrequest,
    input  logic         retire,
    output logic         all_issued
);

    localparam int          HW   = $clog2(DEPTH + 1);
    localparam logic [W-1:0] STEP = W'(W / 8);

    logic [W-1:0]  ptr_q;
    logic [W-1:0]  left_q;
    logic [HW-1:0] held_q;   // issued and not yet retired
    logic          accept;

    assign rd_read    = enable && (left_q != '0) && (held_q < HW'(DEPTH));
    assign accept     = rd_read && !rd_waitrequest;
    assign rd_address = ptr_q;
    assign all_issued = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            ptr_q  <= src_base;
            left_q <= elem_count;
        end else if (accept) begin
            ptr_q  <= ptr_q + STEP;
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            unique case ({accept, retire})
                2'b10:   held_q <= held_q + 1'b1;
                2'b01:   held_q <= held_q - 1'b1;
                default: held_q <= held_q;
            endcase
        end
    end

    // R4: a stalled read keeps strobe and address
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_read && rd_waitrequest |=> rd_read && $stable(rd_address));

    // R3: back-to-back accepted reads step by one word
    p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rd_read || (rd_address == $past(rd_address) + STEP));

    // R3: nothing retires that was not issued
    p_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> held_q != '0);

endmodule

// File: rtl/mce_fifo.sv
module mce_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store_q [DEPTH];
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout      = store_q[rp_q];
    assign not_empty = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (push) store_q[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wrap_inc(wp_q);
            if (pop)  rp_q <= wrap_inc(rp_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3: read data never arrives into a full buffer
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> cnt_q != CW'(DEPTH));

    // R5: elements are only consumed when present
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0);

endmodule

// File: rtl/mce_store.sv
module mce_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dst_base,
    input  logic [W-1:0] elem_count,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] cmpv,
    input  logic         invert,
    input  logic         head_valid,
    input  logic [W-1:0] head_data,
    output logic         pop,
    output logic [W-1:0] wr_address,
    output logic         wr_write,
    output logic [W-1:0] wr_writedata,
    input  logic         wr_waitrequest,
    output logic         all_retired
);

    localparam logic [W-1:0] STEP = W'(W / 8);

    logic [W-1:0] ptr_q;
    logic [W-1:0] left_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] cmp_q;
    logic         inv_q;
    logic         pass;

    assign pass         = ((head_data & mask_q) != cmp_q) ^ inv_q;
    assign wr_write     = head_valid && pass;
    assign wr_writedata = head_data;
    assign wr_address   = ptr_q;
    // a rejected element retires at once; a passing one when taken
    assign pop          = head_valid && (!pass || !wr_waitrequest);
    assign all_retired  = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
            mask_q <= '0;
            cmp_q  <= '0;
            inv_q  <= 1'b0;
        end else if (load) begin
            ptr_q  <= dst_base;
            left_q <= elem_count;
            mask_q <= mask;
            cmp_q  <= cmpv;
            inv_q  <= invert;
        end else if (pop) begin
            ptr_q  <= ptr_q + STEP;
            left_q <= left_q - 1'b1;
        end
    end

    // R4: a stalled write keeps strobe, address and data
    p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_write && wr_waitrequest |=> wr_write && $stable(wr_address)
                                       && $stable(wr_writedata));

    // R11: no element retires beyond the programmed count
    p_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> left_q != '0);

endmodule

// File: rtl/mask_copy_engine.sv
module mask_copy_engine
    import mce_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_address,
    input  logic              csr_write,
    input  logic [W-1:0]      csr_writedata,
    output logic [W-1:0]      csr_readdata,
    output logic [W-1:0]      rd_address,
    output logic              rd_read,
    input  logic              rd_waitrequest,
    input  logic [W-1:0]      rd_readdata,
    input  logic              rd_readdatavalid,
    output logic [W-1:0]      wr_address,
    output logic              wr_write,
    output logic [W-1:0]      wr_writedata,
    input  logic              wr_waitrequest
);

    eng_state_t state_q, state_d;

    logic         busy, finish, fetch_en, start_go;
    logic [W-1:0] src_base, dst_base, elem_count, mask, cmpv;
    logic         invert;
    logic         all_issued, all_retired;
    logic         head_valid, retire;
    logic [W-1:0] head_data;

    mce_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .csr_address(csr_address), .csr_write(csr_write),
        .csr_writedata(csr_writedata), .csr_readdata(csr_readdata),
        .busy(busy), .finish(finish), .start_go(start_go),
        .src_base(src_base), .dst_base(dst_base), .elem_count(elem_count),
        .mask(mask), .cmpv(cmpv), .invert(invert)
    );

    mce_fetch #(.W(W), .DEPTH(DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .load(start_go),
        .src_base(src_base), .elem_count(elem_count), .enable(fetch_en),
        .rd_address(rd_address), .rd_read(rd_read),
        .rd_waitrequest(rd_waitrequest), .retire(retire),
        .all_issued(all_issued)
    );

    mce_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rd_readdatavalid), .din(rd_readdata),
        .pop(retire), .dout(head_data), .not_empty(head_valid)
    );

    mce_store #(.W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(start_go),
        .dst_base(dst_base), .elem_count(elem_count),
        .mask(mask), .cmpv(cmpv), .invert(invert),
        .head_valid(head_valid), .head_data(head_data), .pop(retire),
        .wr_address(wr_address), .wr_write(wr_write),
        .wr_writedata(wr_writedata), .wr_waitrequest(wr_waitrequest),
        .all_retired(all_retired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_go)    state_d = S_LOAD;
            S_LOAD:   state_d = all_issued ? S_FINISH : S_STREAM;
            S_STREAM: if (all_issued)  state_d = S_DRAIN;
            S_DRAIN:  if (all_retired) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy     = 1'b1;
        fetch_en = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            S_IDLE:   busy     = 1'b0;
            S_LOAD:   ;
            S_STREAM: fetch_en = 1'b1;
            S_DRAIN:  ;
            S_FINISH: finish   = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

    // R11: no bus activity while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !rd_read && !wr_write);

    // R11: the run only ends after every element has retired
    p_finish_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |-> !head_valid && all_retired);

    // R10: a run that issued nothing writes nothing
    p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) && all_issued |-> !wr_write);

endmodule

// File: tb/mask_copy_engine_test.sv
module mask_copy_engine_test;
    import mce_pkg::*;

    localparam int W   = 32;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [CSR_AW-1:0] csr_address = '0;
    logic              csr_write = 1'b0;
    logic [W-1:0]      csr_writedata = '0;
    logic [W-1:0]      csr_readdata;
    logic [W-1:0]      rd_address;
    logic              rd_read;
    logic              rd_waitrequest = 1'b0;
    logic [W-1:0]      rd_readdata = '0;
    logic              rd_readdatavalid = 1'b0;
    logic [W-1:0]      wr_address;
    logic              wr_write;
    logic [W-1:0]      wr_writedata;
    logic              wr_waitrequest = 1'b0;

    mask_copy_engine #(.W(W), .DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .csr_address(csr_address), .csr_write(csr_write),
        .csr_writedata(csr_writedata), .csr_readdata(csr_readdata),
        .rd_address(rd_address), .rd_read(rd_read),
        .rd_waitrequest(rd_waitrequest), .rd_readdata(rd_readdata),
        .rd_readdatavalid(rd_readdatavalid),
        .wr_address(wr_address), .wr_write(wr_write),
        .wr_writedata(wr_writedata), .wr_waitrequest(wr_waitrequest)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int activity = 0;
    bit rwait_en = 1'b0;
    bit wwait_en = 1'b0;
    logic [15:0] lf = 16'hACE1;

    // reference model state
    logic [W-1:0] ex_ra[$];
    logic [W-1:0] ex_wa[$];
    logic [W-1:0] ex_wd[$];
    logic [W-1:0] rq_data[$];
    int unsigned  rq_due[$];
    logic [W-1:0] dmem [logic [W-1:0]];

    logic [W-1:0] cfg_src, cfg_dst, cfg_n, cfg_mask, cfg_cmp;
    bit           cfg_inv;

    function automatic logic [W-1:0] sword(input logic [W-1:0] a);
        return (a * 32'h9E37_79B1) ^ (a >> 5) ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [W-1:0] marker(input int i);
        return 32'hDEAD_0000 | W'(i);
    endfunction

    function automatic bit passes(input logic [W-1:0] d);
        return (((d & cfg_mask) != cfg_cmp) ? 1'b1 : 1'b0) ^ cfg_inv;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model and per-clock bus comparison
    logic         rd_stall_prev = 1'b0, wr_stall_prev = 1'b0;
    logic [W-1:0] rd_addr_prev = '0, wr_addr_prev = '0, wr_data_prev = '0;

    always begin
        @(negedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rd_waitrequest = rwait_en && (lf[1:0] == 2'b00);
        wr_waitrequest = wwait_en && (lf[4:3] == 2'b00);
        if (rq_due.size() != 0 && rq_due[0] <= cyc) begin
            rd_readdatavalid = 1'b1;
            rd_readdata = rq_data.pop_front();
            void'(rq_due.pop_front());
        end else begin
            rd_readdatavalid = 1'b0;
            rd_readdata = '0;
        end
        #1;
        if (rst_n) begin
            if (rd_read || wr_write) activity++;
            if (rd_stall_prev)
                chk(rd_read && rd_address == rd_addr_prev, "R4",
                    "stalled read address", rd_address, rd_addr_prev);
            if (wr_stall_prev)
                chk(wr_write && wr_address == wr_addr_prev
                    && wr_writedata == wr_data_prev, "R4",
                    "stalled write data", wr_writedata, wr_data_prev);
            rd_stall_prev = rd_read && rd_waitrequest;
            wr_stall_prev = wr_write && wr_waitrequest;
            rd_addr_prev  = rd_address;
            wr_addr_prev  = wr_address;
            wr_data_prev  = wr_writedata;
            if (rd_read && !rd_waitrequest) begin
                if (ex_ra.size() == 0) begin
                    chk(1'b0, "R3", "unexpected read", rd_address, '0);
                end else begin
                    logic [W-1:0] ea;
                    ea = ex_ra.pop_front();
                    chk(rd_address == ea, "R3", "read address", rd_address, ea);
                end
                rq_data.push_back(sword(rd_address));
                rq_due.push_back(cyc + LAT);
            end
            if (wr_write && !wr_waitrequest) begin
                if (ex_wa.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", wr_address, '0);
                end else begin
                    logic [W-1:0] ea, ed;
                    ea = ex_wa.pop_front();
                    ed = ex_wd.pop_front();
                    chk(wr_address == ea, "R5", "write address", wr_address, ea);
                    chk(wr_writedata == ed, "R5", "write data", wr_writedata, ed);
                end
                dmem[wr_address] = wr_writedata;
            end
        end
    end

    task automatic csr_wr(input logic [CSR_AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk); #2;
        csr_address = a; csr_writedata = d; csr_write = 1'b1;
        @(negedge clk); #2;
        csr_write = 1'b0;
    endtask

    task automatic csr_rd(input logic [CSR_AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk); #2;
        csr_address = a;
        #1 d = csr_readdata;
    endtask

    task automatic program_run(input logic [W-1:0] s, input logic [W-1:0] d,
                               input logic [W-1:0] n, input logic [W-1:0] m,
                               input logic [W-1:0] c, input bit inv);
        cfg_src = s; cfg_dst = d; cfg_n = n; cfg_mask = m; cfg_cmp = c; cfg_inv = inv;
        csr_wr(A_SRC, s);
        csr_wr(A_DST, d);
        csr_wr(A_CNT, n);
        csr_wr(A_MASK, m);
        csr_wr(A_CMP, c);
        csr_wr(A_CTRL, W'(inv) << B_INV);
    endtask

    task automatic build_expect();
        for (int i = 0; i < int'(cfg_n); i++) begin
            logic [W-1:0] a, d;
            a = cfg_src + W'(4 * i);
            d = sword(a);
            ex_ra.push_back(a);
            dmem[cfg_dst + W'(4 * i)] = marker(i);
            if (passes(d)) begin
                ex_wa.push_back(cfg_dst + W'(4 * i));
                ex_wd.push_back(d);
            end
        end
    endtask

    task automatic start_run();
        csr_wr(A_CTRL, (W'(cfg_inv) << B_INV) | 32'h1);
    endtask

    task automatic wait_idle(output int cycles);
        logic [W-1:0] s;
        int unsigned t0;
        t0 = cyc;
        for (int k = 0; k < 3000; k++) begin
            csr_rd(A_STAT, s);
            if (!s[B_BUSY]) break;
        end
        cycles = int'(cyc - t0);
    endtask

    task automatic post_run();
        logic [W-1:0] s;
        chk(ex_ra.size() == 0, "R3", "reads left unissued", W'(ex_ra.size()), '0);
        chk(ex_wa.size() == 0, "R11", "writes pending at idle", W'(ex_wa.size()), '0);
        csr_rd(A_STAT, s);
        chk(s == 32'h2, "R8", "status after run", s, 32'h2);
        for (int i = 0; i < int'(cfg_n); i++) begin
            logic [W-1:0] a, d, got;
            a = cfg_dst + W'(4 * i);
            d = sword(cfg_src + W'(4 * i));
            got = dmem[a];
            if (passes(d)) chk(got == d, "R5", "written word", got, d);
            else           chk(got == marker(i), "R6", "skipped word", got, marker(i));
        end
    endtask

    initial begin
        logic [W-1:0] s;
        int cyc_n;
        int act0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        csr_rd(A_STAT, s);
        chk(s == '0, "R1", "status after reset", s, '0);
        chk(!rd_read && !wr_write, "R1", "strobes after reset",
            W'({rd_read, wr_write}), '0);

        // R7: throughput with no stalls, R5 filter
        rwait_en = 1'b0; wwait_en = 1'b0;
        program_run(32'h0000_1000, 32'h0000_8000, 32, 32'h1, 32'h0, 1'b0);
        build_expect();
        start_run();
        wait_idle(cyc_n);
        chk(cyc_n <= 32 + LAT + 8, "R7", "cycles for 32 elements",
            W'(cyc_n), W'(32 + LAT + 8));
        post_run();

        // R2: setup retained
        csr_rd(A_SRC, s);  chk(s == cfg_src,  "R2", "source readback", s, cfg_src);
        csr_rd(A_DST, s);  chk(s == cfg_dst,  "R2", "dest readback", s, cfg_dst);
        csr_rd(A_CNT, s);  chk(s == cfg_n,    "R2", "count readback", s, cfg_n);
        csr_rd(A_MASK, s); chk(s == cfg_mask, "R2", "mask readback", s, cfg_mask);
        csr_rd(A_CMP, s);  chk(s == cfg_cmp,  "R2", "compare readback", s, cfg_cmp);

        // R5 with invert, stalls on both masters (R4), R8 busy while running
        rwait_en = 1'b1; wwait_en = 1'b1;
        program_run(32'h0000_2040, 32'h0000_9000, 40, 32'h30, 32'h10, 1'b1);
        build_expect();
        start_run();
        csr_rd(A_STAT, s);
        chk(s == 32'h1, "R8", "status while running", s, 32'h1);
        wait_idle(cyc_n);
        post_run();
        csr_rd(A_CTRL, s);
        chk(s == 32'h2, "R2", "invert readback", s, 32'h2);

        // R2: repeat with start only
        build_expect();
        start_run();
        wait_idle(cyc_n);
        post_run();

        // R9: start and count change during a run
        program_run(32'h0000_3000, 32'h0000_A000, 24, 32'hF, 32'h5, 1'b0);
        build_expect();
        start_run();
        repeat (3) @(negedge clk);
        csr_wr(A_CNT, 32'd3);
        csr_wr(A_CTRL, 32'h1);
        wait_idle(cyc_n);
        post_run();
        csr_rd(A_CNT, s);
        chk(s == 32'd3, "R9", "count written during run", s, 32'd3);

        // R10: zero count
        csr_wr(A_CNT, 32'd0);
        cfg_n = 0;
        act0 = activity;
        start_run();
        wait_idle(cyc_n);
        repeat (4) @(negedge clk);
        csr_rd(A_STAT, s);
        chk(s == 32'h2, "R10", "done after zero count", s, 32'h2);
        chk(activity == act0, "R10", "strobes on zero count",
            W'(activity - act0), '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule